// File: doc/BRIEF.md
# Video Control Register Bank with Two-Wire Serial Slave

This block is a two-wire serial (I2C) slave that owns a bank of 8-bit control registers for a video processing chain. SCL and SDA are sampled by a fast system clock through synchronisers. The block detects START and STOP in the system domain and answers only its fixed 7-bit module address. A write carries a subaddress byte and then data bytes. The subaddress picks the first register. When auto-increment is on, the pointer moves forward after each byte.

Written values can reach the active registers at once. They can instead wait in shadow registers and be applied together on the rising edge of a vertical-blanking input, so that a picture never shows a half-applied setting. A read transfer returns a live status byte taken from external comparison flags. SDA is open-drain and is modelled as an output-enable: when the enable is high, the line is pulled low.

Top module: `vbi_i2c_regbank`

## Requirements
- R1: After reset every active register is 0, `sda_oe_o` is 0 and `busy_o` is 0.
- R2: `busy_o` goes high after a START (SDA falling while SCL high) and returns low after a STOP (SDA rising while SCL high). SDA is never driven while the bus is idle.
- R3: Address byte 0x88 (module address 1000100, write) is acknowledged by driving SDA low during the ninth clock. Any other address is not acknowledged. Every later byte up to the next START is then ignored and leaves the registers unchanged.
- R4: With `autoinc_i` = 0, a write takes the form address, subaddress, one data byte. The subaddress and the data byte are both acknowledged, and the data lands in the register at that subaddress.
- R5: With `autoinc_i` = 0, a second data byte in the same transfer is not acknowledged and is not written.
- R6: With `autoinc_i` = 1, every data byte is acknowledged and goes to the next register in turn. At entry 15 the pointer stops, so later bytes overwrite entry 15 and never wrap to entry 0.
- R7: A subaddress of 16 or more is acknowledged, and so are its data bytes, but no register changes.
- R8: With `defer_i` = 0, a written value appears on `regs_o` before the transfer's STOP. Entry i sits at bits [8i+7:8i].
- R9: With `defer_i` = 1, written values leave `regs_o` unchanged until the next rising edge of `vblank_i`. On that edge all pending entries are copied at once.
- R10: With `defer_i` = 1, a data byte whose write lands in the same clock as a `vblank_i` rising edge is held back to the following rising edge. Entries that were pending before that edge are still committed on it.
- R11: Address byte 0x89 (read) is acknowledged, and the block then sends `cmp_flags_i` MSB first. It sends a further byte for each master acknowledge. After a master not-acknowledge it releases SDA until the next START. SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Bus busy between START and STOP |
| autoinc_i | input | 1 | Subaddress auto-increment enable |
| defer_i | input | 1 | Hold writes until the vertical-blank edge |
| vblank_i | input | 1 | Vertical-blanking level, synchronous to clk_i |
| cmp_flags_i | input | 8 | Comparison flags returned on read |
| regs_o | output | 128 | Active registers, entry i at [8i+7:8i] |

## Verification
The bench sweeps every subaddress with distinct data, and it reads a range of flag patterns. This exposes a pointer that is loaded wrongly and a bit order that is reversed on either direction. It also pushes auto-increment past entry 15, where a pointer that wraps would corrupt entry 0. It sends a subaddress out of range, which a design that failed to range-check would alias onto a real entry. It sends a second byte without auto-increment, which a faulty design would acknowledge or store. In deferred mode it lines up the last data byte with the blanking edge to the exact clock. A design that committed that byte early, or that dropped the entries already pending, shows the wrong register values after the first edge.

// File: rtl/vrb_pkg.sv
package vrb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
    ST_DATA, ST_DATA_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } vrb_state_e;
endpackage

// File: rtl/vrb_bus_sense.sv
module vrb_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_o;
      sda_q    <= sda_o;
    end
  end

  assign scl_o      = scl_sync[SYNC_STAGES-1];
  assign sda_o      = sda_sync[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/vrb_proto.sv
module vrb_proto
  import vrb_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter logic [DATA_W-2:0] DEV_ADDR = 7'b1000100,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              autoinc_i,
  input  logic [DATA_W-1:0] cmp_flags_i,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output vrb_state_e        state_o
);
  vrb_state_e        state;
  logic [DATA_W-1:0] rx_sh, tx_sh, ptr;
  logic [CNT_W-1:0]  bitcnt;
  logic              rw_q, data_seen, m_ack;
  logic              byte_done, ptr_ok, accept;

  assign byte_done = scl_fall_i && (bitcnt == CNT_W'(DATA_W));
  assign ptr_ok    = ptr < DATA_W'(NUM_REGS);
  assign accept    = autoinc_i || !data_seen;
  assign wr_en_o   = (state == ST_DATA) && byte_done && accept && ptr_ok;
  assign wr_idx_o  = ptr[IDX_W-1:0];
  assign wr_data_o = rx_sh;
  assign busy_o    = state != ST_IDLE;
  assign state_o   = state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      bitcnt    <= '0;
      rw_q      <= 1'b0;
      data_seen <= 1'b0;
      m_ack     <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else if (start_i) begin
      state    <= ST_ADDR;
      bitcnt   <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_i) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_SUB, ST_DATA: begin
          if (scl_rise_i) begin
            rx_sh  <= {rx_sh[DATA_W-2:0], sda_s_i};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            bitcnt <= '0;
            if (state == ST_ADDR) begin
              if (rx_sh[DATA_W-1:1] == DEV_ADDR) begin
                rw_q     <= rx_sh[0];
                sda_oe_o <= 1'b1;
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end else if (state == ST_SUB) begin
              ptr       <= rx_sh;
              data_seen <= 1'b0;
              sda_oe_o  <= 1'b1;
              state     <= ST_SUB_ACK;
            end else if (accept) begin
              data_seen <= 1'b1;
              sda_oe_o  <= 1'b1;
              state     <= ST_DATA_ACK;
              if (autoinc_i && ptr < DATA_W'(NUM_REGS - 1)) ptr <= ptr + 1'b1;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall_i) begin
          if (rw_q) begin
            tx_sh    <= cmp_flags_i;
            sda_oe_o <= ~cmp_flags_i[DATA_W-1];
            state    <= ST_RD;
          end else begin
            sda_oe_o <= 1'b0;
            state    <= ST_SUB;
          end
        end
        ST_SUB_ACK, ST_DATA_ACK: if (scl_fall_i) begin
          sda_oe_o <= 1'b0;
          state    <= ST_DATA;
        end
        ST_RD: begin
          if (scl_rise_i) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            bitcnt   <= '0;
            sda_oe_o <= 1'b0;
            state    <= ST_RD_ACK;
          end else if (scl_fall_i) begin
            tx_sh    <= {tx_sh[DATA_W-2:0], 1'b0};
            sda_oe_o <= ~tx_sh[DATA_W-2];
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            m_ack <= ~sda_s_i;
          end else if (scl_fall_i) begin
            if (m_ack) begin
              tx_sh    <= cmp_flags_i;
              sda_oe_o <= ~cmp_flags_i[DATA_W-1];
              state    <= ST_RD;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vrb_bank.sv
module vrb_bank #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int REGS_W = NUM_REGS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              defer_i,
  input  logic              vblank_i,
  output logic [REGS_W-1:0] regs_o
);
  logic vb_q, vb_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vb_q <= 1'b0;
    else         vb_q <= vblank_i;
  end
  assign vb_rise = vblank_i & ~vb_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    logic [DATA_W-1:0] act, shd;
    logic              pend, hit;

    assign hit = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act  <= '0;
        shd  <= '0;
        pend <= 1'b0;
      end else if (hit && !defer_i) begin
        act  <= wr_data_i;
        pend <= 1'b0;
      end else if (hit) begin
        shd  <= wr_data_i;
        pend <= 1'b1;  // lands after any coincident edge
      end else if (vb_rise && pend) begin
        act  <= shd;
        pend <= 1'b0;
      end
    end

    assign regs_o[i*DATA_W +: DATA_W] = act;
  end
endmodule

// File: rtl/vbi_i2c_regbank.sv
module vbi_i2c_regbank
  import vrb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-2:0] DEV_ADDR = 7'b1000100,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int REGS_W = NUM_REGS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              busy_o,
  input  logic              autoinc_i,
  input  logic              defer_i,
  input  logic              vblank_i,
  input  logic [DATA_W-1:0] cmp_flags_i,
  output logic [REGS_W-1:0] regs_o
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  vrb_state_e        state;

  vrb_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  vrb_proto #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_proto (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .autoinc_i, .cmp_flags_i,
    .sda_oe_o, .busy_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .state_o(state)
  );

  vrb_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .defer_i, .vblank_i, .regs_o
  );
endmodule

// File: rtl/vrb_checker.sv
module vrb_checker
  import vrb_pkg::*;
#(
  parameter int REGS_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_oe_i,
  input logic              busy_i,
  input logic              scl_s_i,
  input logic              start_i,
  input logic              stop_i,
  input logic              wr_en_i,
  input logic              vblank_i,
  input vrb_state_e        state_i,
  input logic [REGS_W-1:0] regs_i
);
  logic vb_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vb_q <= 1'b0;
    else         vb_q <= vblank_i;
  end

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_i);
  // R2
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !busy_i);
  // R2
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !sda_oe_i);
  // R3
  skip_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SKIP) |-> !sda_oe_i);
  // R11
  drive_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !$past(scl_s_i));
  // R9
  reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !(vblank_i && !vb_q)) |=> $stable(regs_i));
endmodule

bind vbi_i2c_regbank vrb_checker #(.REGS_W(REGS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_i(sda_oe_o), .busy_i(busy_o),
  .scl_s_i(scl_s), .start_i(start_det), .stop_i(stop_det), .wr_en_i(wr_en),
  .vblank_i(vblank_i), .state_i(state), .regs_i(regs_o)
);

// File: tb/vbi_i2c_regbank_tb_top.sv
`timescale 1ns/1ps
module vbi_i2c_regbank_tb_top;
  localparam int Q = 8;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         m_scl = 1'b1, m_sda = 1'b1;
  logic         autoinc = 1'b0, defer = 1'b0, vblank = 1'b0;
  logic [7:0]   flags = '0;
  logic         sda_oe, busy, sda_line;
  logic [127:0] regs;
  logic [7:0]   mdl [0:15];
  logic [7:0]   dbuf [0:7];
  int           total = 0, bad = 0;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  vbi_i2c_regbank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .busy_o(busy), .autoinc_i(autoinc), .defer_i(defer),
    .vblank_i(vblank), .cmp_flags_i(flags), .regs_o(regs)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model_vec();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit vb_sync, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0;
      if (i == 0 && vb_sync) begin
        @(posedge clk); @(posedge clk); @(negedge clk);
        vblank = 1'b1;
        tick(Q - 2);
      end else begin
        tick(Q);
      end
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    ack = sda_oe;
    tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit m_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_scl = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q); m_scl = 1'b0;
    end
    tick(Q);
    m_sda = ~m_ack; tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic wr_txn(input logic [7:0] dev, input logic [7:0] sub, input int n,
                        input bit vb_last, output logic [9:0] ackv);
    bit a;
    ackv = '0;
    i2c_start();
    send_byte(dev, 1'b0, a); ackv[0] = a;
    send_byte(sub, 1'b0, a); ackv[1] = a;
    for (int k = 0; k < n; k++) begin
      send_byte(dbuf[k], vb_last && (k == n - 1), a);
      ackv[k+2] = a;
    end
    i2c_stop();
  endtask

  task automatic pulse_vblank();
    vblank = 1'b1; tick(4); vblank = 1'b0; tick(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] ackv;
    logic [7:0] rb, rb2;
    bit a;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    tick(3); rst_n = 1'b1; tick(4);

    // R1 reset state
    check("R1 regs", regs, '0);
    check("R1 oe", {127'd0, sda_oe}, '0);
    check("R1 busy", {127'd0, busy}, '0);

    // R2 busy window
    i2c_start();
    check("R2 busy after start", {127'd0, busy}, 128'd1);
    i2c_stop();
    check("R2 busy after stop", {127'd0, busy}, '0);

    // R4 R8 single-byte sweep over every subaddress
    for (int i = 0; i < 16; i++) begin
      dbuf[0] = 8'((i * 37 + 5) ^ 8'hA5);
      wr_txn(8'h88, 8'(i), 1, 1'b0, ackv);
      mdl[i] = dbuf[0];
      check("R3 R4 acks", {118'd0, ackv}, 128'h7);
      check("R8 entry", {120'd0, regs[i*8 +: 8]}, {120'd0, mdl[i]});
    end
    check("R8 bank", regs, model_vec());

    // R5 second byte without auto-increment
    dbuf[0] = 8'hA1; dbuf[1] = 8'hB2;
    wr_txn(8'h88, 8'd3, 2, 1'b0, ackv);
    mdl[3] = 8'hA1;
    check("R5 acks", {118'd0, ackv}, 128'h7);
    check("R5 bank", regs, model_vec());

    // R6 auto-increment stops at last entry
    autoinc = 1'b1;
    for (int k = 0; k < 6; k++) dbuf[k] = 8'hC0 + 8'(k);
    wr_txn(8'h88, 8'd12, 6, 1'b0, ackv);
    mdl[12] = 8'hC0; mdl[13] = 8'hC1; mdl[14] = 8'hC2; mdl[15] = 8'hC5;
    check("R6 acks", {118'd0, ackv}, 128'hFF);
    check("R6 bank", regs, model_vec());

    // R7 subaddress out of range
    dbuf[0] = 8'h3C; dbuf[1] = 8'h4D;
    wr_txn(8'h88, 8'h20, 2, 1'b0, ackv);
    check("R7 acks", {118'd0, ackv}, 128'hF);
    check("R7 bank", regs, model_vec());

    // R3 foreign addresses
    dbuf[0] = 8'hEE;
    wr_txn(8'h90, 8'd0, 1, 1'b0, ackv);
    check("R3 foreign acks", {118'd0, ackv}, '0);
    wr_txn(8'h8A, 8'd1, 1, 1'b0, ackv);
    check("R3 near-miss acks", {118'd0, ackv}, '0);
    check("R3 bank", regs, model_vec());

    // R9 deferred commit
    defer = 1'b1;
    dbuf[0] = 8'hD0; dbuf[1] = 8'hD1;
    wr_txn(8'h88, 8'd0, 2, 1'b0, ackv);
    check("R9 acks", {118'd0, ackv}, 128'hF);
    check("R9 held", regs, model_vec());
    pulse_vblank();
    mdl[0] = 8'hD0; mdl[1] = 8'hD1;
    check("R9 committed", regs, model_vec());

    // R10 write coinciding with the blanking edge
    autoinc = 1'b0;
    dbuf[0] = 8'h77;
    wr_txn(8'h88, 8'd5, 1, 1'b0, ackv);
    dbuf[0] = 8'h66;
    wr_txn(8'h88, 8'd6, 1, 1'b1, ackv);
    vblank = 1'b0; tick(4);
    mdl[5] = 8'h77;
    check("R10 first edge", regs, model_vec());
    pulse_vblank();
    mdl[6] = 8'h66;
    check("R10 second edge", regs, model_vec());
    defer = 1'b0;

    // R11 status reads
    for (int f = 0; f < 8; f++) begin
      flags = 8'((f * 73) ^ 8'h3C);
      i2c_start();
      send_byte(8'h89, 1'b0, a);
      check("R11 addr ack", {127'd0, a}, 128'd1);
      recv_byte(1'b0, rb);
      check("R11 byte", {120'd0, rb}, {120'd0, flags});
      check("R11 released", {127'd0, sda_oe}, '0);
      i2c_stop();
    end
    flags = 8'h81;
    i2c_start();
    send_byte(8'h89, 1'b0, a);
    recv_byte(1'b1, rb);
    recv_byte(1'b0, rb2);
    i2c_stop();
    check("R11 burst", {112'd0, rb, rb2}, {112'd0, 16'h8181});
    check("R11 bank untouched", regs, model_vec());

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule